// File: doc/BRIEF.md
# Four-Input Free-Running Conversion Scan Sequencer

The block drives one shared successive-approximation converter so that it samples up to four analog inputs in turn, without stopping. It selects an input through a one-hot select bus and offers a 10-bit trial code to the external comparator. It then builds the result one bit at a time from the comparator answer and keeps the newest complete result for every input. The conversion rate comes from an internal divider. A 3-bit code sets that divider: it stops the conversion clock or divides the system clock by a power of two.

Software sets the run bit and the per-input enable bits. Input 0 is the master input: while it is disabled, or while the run bit is low, the scan stays idle. To read a stable set of values, software clears the run bit and reads each result as a low byte and a high byte. Clearing the run bit during a conversion throws away the partial result.

The controller is a four-state machine. IDLE waits for a conversion tick while the gate is open and then moves to SETTLE on input 0. SETTLE spends one tick, then loads the trial register and moves to TRIAL. TRIAL spends ten ticks, from the MSB down, and moves to STORE after the LSB. STORE spends one tick, writes the result, pulses the strobe and moves to SETTLE on the next enabled input. From any state the machine returns to IDLE in the next cycle once the gate closes (run low or input 0 disabled).

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the select bus, the trial code, all four results and the strobe are zero.
- R2: Divider code 0 produces no conversion ticks, so nothing changes. Code k in 1..7 produces one tick every 2^(k-1) clocks.
- R3: Each converted input takes exactly 12 ticks (1 settle, 10 trials, 1 store). With only input 0 enabled, strobes are therefore 12·2^(k-1) clocks apart.
- R4: Conversions happen only while run_i is 1 and chan_active_i[0] is 1. If either is 0, the select bus is zero from the next cycle and no result changes.
- R5: Inputs are visited in ascending index order, skipping disabled ones, and wrap from the highest enabled input back to input 0. A new run always starts at input 0.
- R6: The trial code tests bits from 9 down to 0. A bit stays set when cmp_above_i is 1 at the tick that ends its trial. The trial code is zero outside the TRIAL state.
- R7: A result register changes only at the end of a full conversion of its own input. An abort keeps the previously completed value.
- R8: On each result write, new_sample_o is high for exactly one cycle, new_sample_chan_o carries the input index, and the new value is visible on result_o in that same cycle.
- R9: With rd_hi_i = 0, rd_data_o returns result bits 7..0 of input rd_chan_i. With rd_hi_i = 1, it returns six zero bits followed by result bits 9..8.
- R10: mux_sel_o is one-hot with bit i set while input i is in SETTLE, TRIAL or STORE, and zero in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (crystal) clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| chan_active_i | input | 4 | Per-input enable; bit 0 gates the whole scan |
| run_i | input | 1 | 1 = scan continuously, 0 = hold results |
| div_code_i | input | 3 | Conversion clock divider code |
| cmp_above_i | input | 1 | Comparator: selected input ≥ trial code |
| rd_chan_i | input | 2 | Input index to read |
| rd_hi_i | input | 1 | 0 = low byte, 1 = high byte |
| rd_data_o | output | 8 | Read byte |
| mux_sel_o | output | 4 | One-hot analog input select |
| trial_code_o | output | 10 | Code applied to the comparison DAC |
| result_o | output | 40 | Stored results, input i at bits 10i+9..10i |
| new_sample_o | output | 1 | One-cycle result-write strobe |
| new_sample_chan_o | output | 2 | Input index of the write |

## Verification
A wrong state or input index shows on mux_sel_o and trial_code_o in the cycle right after the faulty transition. The bench compares both on every clock, so it reports the fault at once rather than at the next stored result. A wrong divider count shifts the first tick, and so the next select or trial change, by at least one clock. An abort or gating fault appears as a select bus that fails to clear, or as a result that changes without its strobe.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_TRIAL  = 2'd2,
        ST_STORE  = 2'd3
    } scan_state_e;

    localparam int unsigned DEF_N_CH  = 4;
    localparam int unsigned DEF_RES_W = 10;
    localparam int unsigned DEF_DIV_W = 3;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] code_i,
    output logic             tick_o
);
    localparam int unsigned MAX_SH = (1 << DIV_W) - 2;
    localparam int unsigned CNT_W  = (MAX_SH > 0) ? MAX_SH : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;

    always_comb begin
        span  = '0;
        limit = '0;
        if (code_i != '0) begin
            span  = (CNT_W+1)'(1) << (code_i - DIV_W'(1));
            limit = CNT_W'(span - (CNT_W+1)'(1));
        end
    end

    assign tick_o = (code_i != '0) && (cnt_q >= limit);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (code_i == '0 || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int unsigned RES_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] acc_o,
    output logic             last_o
);
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] mask_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q  <= '0;
            mask_q <= '0;
        end else if (start_i) begin
            acc_q  <= '0;
            mask_q <= {1'b1, {(RES_W-1){1'b0}}};
        end else if (step_i) begin
            if (cmp_i) begin
                acc_q <= acc_q | mask_q;
            end
            mask_q <= mask_q >> 1;
        end
    end

    assign trial_o = acc_q | mask_q;
    assign acc_o   = acc_q;
    assign last_o  = mask_q[0];
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned RES_W = 10
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_en_i,
    input  logic [$clog2(N_CH)-1:0] wr_ch_i,
    input  logic [RES_W-1:0]        wr_data_i,
    input  logic [$clog2(N_CH)-1:0] rd_ch_i,
    input  logic                    rd_hi_i,
    output logic [7:0]              rd_data_o,
    output logic [N_CH*RES_W-1:0]   result_o,
    output logic                    strobe_o,
    output logic [$clog2(N_CH)-1:0] strobe_ch_o
);
    localparam int unsigned HI_W = RES_W - 8;

    logic [RES_W-1:0] res_q [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                res_q[g] <= '0;
            end else if (wr_en_i && wr_ch_i == g) begin
                res_q[g] <= wr_data_i;
            end
        end
        assign result_o[g*RES_W +: RES_W] = res_q[g];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            strobe_o    <= 1'b0;
            strobe_ch_o <= '0;
        end else begin
            strobe_o    <= wr_en_i;
            strobe_ch_o <= wr_en_i ? wr_ch_i : strobe_ch_o;
        end
    end

    always_comb begin
        if (rd_hi_i) begin
            rd_data_o = {{(8-HI_W){1'b0}}, res_q[rd_ch_i][RES_W-1:8]};
        end else begin
            rd_data_o = res_q[rd_ch_i][7:0];
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int unsigned N_CH  = DEF_N_CH,
    parameter int unsigned RES_W = DEF_RES_W,
    parameter int unsigned DIV_W = DEF_DIV_W,
    localparam int unsigned CH_W = $clog2(N_CH)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [N_CH-1:0]       chan_active_i,
    input  logic                  run_i,
    input  logic [DIV_W-1:0]      div_code_i,
    input  logic                  cmp_above_i,
    input  logic [CH_W-1:0]       rd_chan_i,
    input  logic                  rd_hi_i,
    output logic [7:0]            rd_data_o,
    output logic [N_CH-1:0]       mux_sel_o,
    output logic [RES_W-1:0]      trial_code_o,
    output logic [N_CH*RES_W-1:0] result_o,
    output logic                  new_sample_o,
    output logic [CH_W-1:0]       new_sample_chan_o
);
    scan_state_e      state_q, state_d;
    logic [CH_W-1:0]  chan_q, chan_d, chan_next;
    logic             tick, go;
    logic             sar_start, sar_step, sar_last;
    logic [RES_W-1:0] sar_trial, sar_acc;
    logic             wr_en;

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (div_code_i),
        .tick_o (tick)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (sar_start),
        .step_i  (sar_step),
        .cmp_i   (cmp_above_i),
        .trial_o (sar_trial),
        .acc_o   (sar_acc),
        .last_o  (sar_last)
    );

    adc_result_bank #(.N_CH(N_CH), .RES_W(RES_W)) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en),
        .wr_ch_i     (chan_q),
        .wr_data_i   (sar_acc),
        .rd_ch_i     (rd_chan_i),
        .rd_hi_i     (rd_hi_i),
        .rd_data_o   (rd_data_o),
        .result_o    (result_o),
        .strobe_o    (new_sample_o),
        .strobe_ch_o (new_sample_chan_o)
    );

    assign go = run_i && chan_active_i[0];

    // next enabled input above the current one, wrapping to input 0
    always_comb begin
        logic found;
        found     = 1'b0;
        chan_next = '0;
        for (int k = 1; k <= int'(N_CH); k++) begin
            int idx;
            idx = (int'(chan_q) + k) % int'(N_CH);
            if (!found && chan_active_i[idx]) begin
                found     = 1'b1;
                chan_next = CH_W'(idx);
            end
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            chan_q  <= chan_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        if (!go) begin
            state_d = ST_IDLE;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_SETTLE;
                    chan_d  = '0;
                end
                ST_SETTLE: state_d = ST_TRIAL;
                ST_TRIAL:  state_d = sar_last ? ST_STORE : ST_TRIAL;
                ST_STORE: begin
                    state_d = ST_SETTLE;
                    chan_d  = chan_next;
                end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mux_sel_o    = '0;
        trial_code_o = '0;
        sar_start    = 1'b0;
        sar_step     = 1'b0;
        wr_en        = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETTLE: begin
                mux_sel_o[chan_q] = 1'b1;
                sar_start         = go && tick;
            end
            ST_TRIAL: begin
                mux_sel_o[chan_q] = 1'b1;
                trial_code_o      = sar_trial;
                sar_step          = go && tick;
            end
            ST_STORE: begin
                mux_sel_o[chan_q] = 1'b1;
                wr_en             = go && tick;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned RES_W = 10,
    parameter int unsigned DIV_W = 3
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [N_CH-1:0]         chan_active_i,
    input logic                    run_i,
    input logic [DIV_W-1:0]        div_code_i,
    input logic [N_CH-1:0]         mux_sel_o,
    input logic [RES_W-1:0]        trial_code_o,
    input logic [N_CH*RES_W-1:0]   result_o,
    input logic                    new_sample_o
);
    p_sel_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(mux_sel_o));

    p_gate_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(run_i && chan_active_i[0]) |=> (mux_sel_o == '0 && !new_sample_o));

    p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_sample_o |=> !new_sample_o);

    p_hold_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !new_sample_o |-> $stable(result_o));

    p_trial_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mux_sel_o == '0) |-> (trial_code_o == '0));

    p_div_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_code_i == '0 && run_i && chan_active_i[0])
            |=> ($stable(mux_sel_o) && $stable(trial_code_o)));
endmodule

bind adc_scan_seq adc_scan_chk #(.N_CH(N_CH), .RES_W(RES_W), .DIV_W(DIV_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .chan_active_i (chan_active_i),
    .run_i         (run_i),
    .div_code_i    (div_code_i),
    .mux_sel_o     (mux_sel_o),
    .trial_code_o  (trial_code_o),
    .result_o      (result_o),
    .new_sample_o  (new_sample_o)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  act = '0;
    logic        run = 1'b0;
    logic [2:0]  div = '0;
    logic        cmp;
    logic [1:0]  rd_ch = '0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  sel;
    logic [9:0]  trial;
    logic [39:0] res;
    logic        stb;
    logic [1:0]  stb_ch;

    int vin [4] = '{0, 0, 0, 0};
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    adc_scan_seq dut (
        .clk_i(clk), .rst_ni(rst_n), .chan_active_i(act), .run_i(run),
        .div_code_i(div), .cmp_above_i(cmp), .rd_chan_i(rd_ch), .rd_hi_i(rd_hi),
        .rd_data_o(rd_data), .mux_sel_o(sel), .trial_code_o(trial),
        .result_o(res), .new_sample_o(stb), .new_sample_chan_o(stb_ch)
    );

    // analog side: multiplexer and comparator
    always_comb begin
        int v;
        v = 0;
        for (int i = 0; i < 4; i++) if (sel[i]) v = vin[i];
        cmp = (v >= int'(trial));
    end

    // behavioural reference model
    int m_st = 0, m_ch = 0, m_bit = 0, m_acc = 0, m_dcnt = 0;
    int m_res [4] = '{0, 0, 0, 0};
    bit m_stb = 0;
    int m_sch = 0;

    always @(posedge clk) begin
        int lim;
        bit tk;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_ch = 0; m_bit = 0; m_acc = 0; m_dcnt = 0; m_stb = 0; m_sch = 0;
            for (int i = 0; i < 4; i++) m_res[i] = 0;
        end else begin
            lim = (div == 0) ? 0 : (1 << (div - 1)) - 1;
            tk = (div != 0) && (m_dcnt >= lim);
            m_dcnt = (div == 0 || tk) ? 0 : m_dcnt + 1;
            m_stb = 0;
            if (!(run && act[0])) m_st = 0;
            else if (tk) begin
                case (m_st)
                    0: begin m_st = 1; m_ch = 0; end
                    1: begin m_st = 2; m_acc = 0; m_bit = 9; end
                    2: begin
                        if (vin[m_ch] >= (m_acc + (1 << m_bit))) m_acc += (1 << m_bit);
                        if (m_bit == 0) m_st = 3; else m_bit--;
                    end
                    default: begin
                        m_res[m_ch] = m_acc; m_stb = 1; m_sch = m_ch;
                        for (int k = 1; k <= 4; k++)
                            if (act[(m_sch + k) % 4]) begin m_ch = (m_sch + k) % 4; break; end
                        m_st = 1;
                    end
                endcase
            end
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog R3 run did not finish: actual=%0d cycles expected<=150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act_v, exp_v, cyc);
        end
    endtask

    // per-clock comparison against the model, away from the active edge
    bit mon_on = 0;
    int seq_q[$];
    int tim_q[$];
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R10/R5 select", int'(sel), (m_st == 0) ? 0 : (1 << m_ch));
            chk("R6 trial code", int'(trial), (m_st == 2) ? (m_acc | (1 << m_bit)) : 0);
            chk("R8 strobe", int'(stb), int'(m_stb));
            if (m_stb) chk("R8 strobe channel", int'(stb_ch), m_sch);
            for (int i = 0; i < 4; i++) chk("R7 result", int'(res[i*10 +: 10]), m_res[i]);
            if (stb) begin seq_q.push_back(int'(stb_ch)); tim_q.push_back(cyc); end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [3:0] a, input logic [2:0] d);
        run = 1'b0;
        wait_clk(2);
        act = a; div = d;
        seq_q.delete(); tim_q.delete();
        run = 1'b1;
    endtask

    initial begin
        wait_clk(3);
        // R1 reset state
        chk("R1 select", int'(sel), 0);
        chk("R1 trial", int'(trial), 0);
        chk("R1 results", int'(res != '0), 0);
        chk("R1 strobe", int'(stb), 0);
        rst_n = 1'b1;
        mon_on = 1;

        // R2: divider code 0 stops everything
        vin = '{700, 1023, 341, 512};
        act = 4'b1111; run = 1'b1; div = 3'd0;
        wait_clk(200);
        chk("R2 no activity at code 0", int'(sel), 0);
        chk("R2 no strobes at code 0", seq_q.size(), 0);

        // R3/R6: single input, divide by 1
        restart(4'b0001, 3'd1);
        wait_clk(60);
        chk("R3 strobe spacing div1", tim_q[1] - tim_q[0], 12);
        chk("R6 result input0", int'(res[9:0]), 700);

        // R5: all inputs, divide by 2
        restart(4'b1111, 3'd2);
        wait_clk(230);
        for (int i = 0; i < 6; i++) chk("R5 order all", seq_q[i], i % 4);
        chk("R6 result input1 full scale", int'(res[19:10]), 1023);
        chk("R6 result input2", int'(res[29:20]), 341);
        chk("R6 result input3", int'(res[39:30]), 512);

        // R5: skip a disabled input
        vin[1] = 77; vin[3] = 900;
        restart(4'b1011, 3'd1);
        wait_clk(90);
        chk("R5 skip seq0", seq_q[0], 0);
        chk("R5 skip seq1", seq_q[1], 1);
        chk("R5 skip seq2", seq_q[2], 3);
        chk("R5 wrap seq3", seq_q[3], 0);
        chk("R5 input2 untouched", int'(res[29:20]), 341);

        // R4: input 0 disabled blocks everything
        vin[2] = 5;
        restart(4'b1110, 3'd1);
        wait_clk(100);
        chk("R4 no strobes without input0", seq_q.size(), 0);
        chk("R4 select idle", int'(sel), 0);
        chk("R4 input2 held", int'(res[29:20]), 341);

        // R7: abort mid-conversion keeps old value
        vin[0] = 100;
        restart(4'b0001, 3'd3);
        wait_clk(20);
        run = 1'b0;
        wait_clk(100);
        chk("R7 aborted result kept", int'(res[9:0]), 700);
        chk("R7 no strobe on abort", seq_q.size(), 0);

        // R9: byte reads
        rd_ch = 2'd3; rd_hi = 1'b0; wait_clk(1);
        chk("R9 low byte", int'(rd_data), 900 & 8'hFF);
        rd_hi = 1'b1; wait_clk(1);
        chk("R9 high byte", int'(rd_data), 900 >> 8);
        rd_ch = 2'd1; wait_clk(1);
        chk("R9 high byte input1", int'(rd_data), 0);
        rd_hi = 1'b0; wait_clk(1);
        chk("R9 low byte input1", int'(rd_data), 77);

        // R2: largest divider
        restart(4'b0001, 3'd7);
        wait_clk(1700);
        chk("R2 strobe spacing div64", tim_q[1] - tim_q[0], 768);
        chk("R6 result after div64", int'(res[9:0]), 100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule